// File: doc/BRIEF.md
# Strip-Mined Strided Vector Address Generator

This block turns one vector memory command into a stream of element addresses. A command carries an element count, a base word address and a stride, all supplied at run time. The block cuts the work into strips, each no longer than a fixed maximum vector length (MVL). For each strip it loads a vector-length register, waits a start-up interval, then offers one element address per clock to an interleaved multi-bank memory.

Every address is split into a bank index and an in-bank offset. Each bank is tracked as busy for a fixed number of cycles after it has been accessed. An address aimed at a busy bank is held back until that bank is free. Nothing is dropped or reordered. Flags mark the first and the last element of each strip, and a one-cycle done pulse closes the command. Moving the data, the vector register file and the memory arrays are handled elsewhere.

Top module: `vec_stride_agu`

## Requirements
- R1: While reset is asserted and after it is released, `cmd_ready` is 1, and `addr_valid` and `done` are 0.
- R2: The first strip holds `cmd_count` mod MVL elements, or MVL elements when that remainder is zero. Every later strip holds exactly MVL elements. `vl_out` shows the length of the current strip while its addresses are offered.
- R3: Element k has the word address `cmd_base + k*cmd_stride` modulo 2^ADDR_W. The stride is two's complement, and k counts on without a break across strip boundaries.
- R4: `addr_bank` is the low log2(NBANK) bits of `addr_word`. `addr_offset` is the remaining upper bits.
- R5: The first address of each strip is offered exactly STARTUP+2 cycles after the handshake that opens the strip, if its bank is free. That handshake is the command handshake or the final element of the previous strip. The STARTUP+2 cycles are one load cycle, STARTUP wait cycles, and then the offer.
- R6: After an address to bank b is accepted in cycle t, no address to b is offered before cycle t+BUSY_CYC. Any other due element is offered as soon as its bank is free, with no extra stall.
- R7: While `addr_valid` is 1 and `addr_ready` is 0, the address and its flags hold steady. The stream loses no elements and does not change their order.
- R8: A stride of zero gives `cmd_count` accesses to the same address.
- R9: `done` is a single-cycle pulse in the cycle after the final element is accepted. A command with count 0 gives no addresses and pulses `done` in the cycle after it is accepted.
- R10: `cmd_ready` is 0 from the cycle after acceptance until the cycle of `done`. A command presented during that time is ignored.
- R11: `addr_first` is 1 on the first element of each strip and `addr_last` on its last element. Both are 0 when `addr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_count | input | CNT_W | Total element count |
| cmd_base | input | ADDR_W | Word address of element 0 |
| cmd_stride | input | ADDR_W | Two's complement word stride |
| addr_valid | output | 1 | Element address offered |
| addr_ready | input | 1 | Memory takes the offered address |
| addr_word | output | ADDR_W | Full word address |
| addr_bank | output | BANK_W | Bank index |
| addr_offset | output | ADDR_W-BANK_W | Word offset inside the bank |
| addr_first | output | 1 | First element of a strip |
| addr_last | output | 1 | Last element of a strip |
| vl_out | output | VL_W | Current strip length |
| done | output | 1 | Command finished pulse |

## Verification
Each result has its own latency:
- The first address of a strip is due STARTUP+2 cycles after the handshake that opened the strip.
- A later element is due one cycle after its predecessor's handshake, or at the earliest free cycle of its bank.
- `done` is due exactly one cycle after the final handshake.

The bench keeps a cycle count sampled on falling edges. From its own handshakes and a per-bank free-cycle table it derives the cycle in which each element becomes due. In every cycle it checks that `addr_valid` is low before that cycle and high from it on. Address, bank, offset, flags and `vl_out` are compared only in cycles where the element is due.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_ISSUE = 2'd3
  } vsa_state_e;
endpackage

// File: rtl/vsa_strip_ctrl.sv
module vsa_strip_ctrl
  import vsa_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int MVL     = 8,
  parameter int STARTUP = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_fire,
  input  logic [CNT_W-1:0]           cmd_count,
  input  logic                       elem_fire,
  output logic                       idle_o,
  output logic                       issuing_o,
  output logic [$clog2(MVL+1)-1:0]   vl_o,
  output logic                       first_o,
  output logic                       last_o,
  output logic                       done_o
);
  localparam int VL_W = $clog2(MVL + 1);
  localparam int SU_W = (STARTUP > 1) ? $clog2(STARTUP) : 1;

  // Length of the next strip given the elements still to issue.
  function automatic logic [CNT_W-1:0] strip_len(input logic [CNT_W-1:0] left);
    logic [CNT_W-1:0] r;
    r = left % CNT_W'(MVL);
    return (r == '0) ? CNT_W'(MVL) : r;
  endfunction

  vsa_state_e         state;
  logic [CNT_W-1:0]   rem;
  logic [VL_W-1:0]    vl;
  logic [VL_W-1:0]    idx;
  logic [SU_W-1:0]    su_cnt;
  logic [CNT_W-1:0]   next_len;
  logic               strip_end;

  assign next_len  = strip_len(rem);
  assign strip_end = (idx == vl - VL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rem    <= '0;
      vl     <= '0;
      idx    <= '0;
      su_cnt <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_fire) begin
            if (cmd_count == '0) done_o <= 1'b1;
            else begin
              rem   <= cmd_count;
              state <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          vl     <= VL_W'(next_len);
          rem    <= rem - next_len;
          idx    <= '0;
          su_cnt <= SU_W'(STARTUP - 1);
          state  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (su_cnt == '0) state <= ST_ISSUE;
          else su_cnt <= su_cnt - SU_W'(1);
        end
        ST_ISSUE: begin
          if (elem_fire) begin
            if (strip_end) begin
              if (rem == '0) begin
                state  <= ST_IDLE;
                done_o <= 1'b1;
              end else begin
                state <= ST_LOAD;
              end
            end else begin
              idx <= idx + VL_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle_o    = (state == ST_IDLE);
  assign issuing_o = (state == ST_ISSUE);
  assign vl_o      = vl;
  assign first_o   = issuing_o && (idx == '0);
  assign last_o    = issuing_o && strip_end;
endmodule

// File: rtl/vsa_addr_step.sv
module vsa_addr_step #(
  parameter int ADDR_W = 16,
  parameter int NBANK  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic [ADDR_W-1:0]                 base,
  input  logic [ADDR_W-1:0]                 stride,
  input  logic                              step,
  output logic [ADDR_W-1:0]                 word_o,
  output logic [$clog2(NBANK)-1:0]          bank_o,
  output logic [ADDR_W-$clog2(NBANK)-1:0]   offset_o
);
  localparam int BANK_W = $clog2(NBANK);

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[BANK_W-1:0];
  endfunction

  function automatic logic [ADDR_W-BANK_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BANK_W];
  endfunction

  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] stride_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      stride_q <= '0;
    end else if (load) begin
      cur      <= base;
      stride_q <= stride;
    end else if (step) begin
      cur <= cur + stride_q;
    end
  end

  assign word_o   = cur;
  assign bank_o   = bank_of(cur);
  assign offset_o = offset_of(cur);
endmodule

// File: rtl/vsa_bank_busy.sv
module vsa_bank_busy #(
  parameter int NBANK    = 4,
  parameter int BUSY_CYC = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire,
  input  logic [$clog2(NBANK)-1:0]  fire_bank,
  input  logic [$clog2(NBANK)-1:0]  query_bank,
  output logic                      busy_o
);
  localparam int CW = (BUSY_CYC > 2) ? $clog2(BUSY_CYC) : 1;

  logic [NBANK-1:0] busy_vec;

  generate
    if (BUSY_CYC <= 1) begin : g_no_track
      assign busy_vec = '0;
    end else begin : g_track
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [CW-1:0] cnt;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) cnt <= '0;
          else if (fire && (fire_bank == b)) cnt <= CW'(BUSY_CYC - 1);
          else if (cnt != '0) cnt <= cnt - CW'(1);
        end
        assign busy_vec[b] = (cnt != '0);
      end
    end
  endgenerate

  assign busy_o = busy_vec[query_bank];
endmodule

// File: rtl/vec_stride_agu.sv
module vec_stride_agu #(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 10,
  parameter int MVL      = 8,
  parameter int NBANK    = 4,
  parameter int BUSY_CYC = 3,
  parameter int STARTUP  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_valid,
  output logic                              cmd_ready,
  input  logic [CNT_W-1:0]                  cmd_count,
  input  logic [ADDR_W-1:0]                 cmd_base,
  input  logic [ADDR_W-1:0]                 cmd_stride,
  output logic                              addr_valid,
  input  logic                              addr_ready,
  output logic [ADDR_W-1:0]                 addr_word,
  output logic [$clog2(NBANK)-1:0]          addr_bank,
  output logic [ADDR_W-$clog2(NBANK)-1:0]   addr_offset,
  output logic                              addr_first,
  output logic                              addr_last,
  output logic [$clog2(MVL+1)-1:0]          vl_out,
  output logic                              done
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int VL_W   = $clog2(MVL + 1);

  // Named internal events, also observed by the bound checker.
  logic cmd_fire;
  logic elem_fire;
  logic issuing;
  logic bank_stall;
  logic bank_busy;
  logic strip_first;
  logic strip_last;
  logic idle;

  assign cmd_ready  = idle;
  assign cmd_fire   = cmd_valid && idle;
  assign bank_stall = issuing && bank_busy;
  assign addr_valid = issuing && !bank_busy;
  assign elem_fire  = addr_valid && addr_ready;
  assign addr_first = addr_valid && strip_first;
  assign addr_last  = addr_valid && strip_last;

  vsa_strip_ctrl #(
    .CNT_W(CNT_W), .MVL(MVL), .STARTUP(STARTUP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_fire(cmd_fire), .cmd_count(cmd_count),
    .elem_fire(elem_fire),
    .idle_o(idle), .issuing_o(issuing),
    .vl_o(vl_out), .first_o(strip_first), .last_o(strip_last),
    .done_o(done)
  );

  vsa_addr_step #(
    .ADDR_W(ADDR_W), .NBANK(NBANK)
  ) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load(cmd_fire), .base(cmd_base), .stride(cmd_stride),
    .step(elem_fire),
    .word_o(addr_word), .bank_o(addr_bank), .offset_o(addr_offset)
  );

  vsa_bank_busy #(
    .NBANK(NBANK), .BUSY_CYC(BUSY_CYC)
  ) u_busy (
    .clk(clk), .rst_n(rst_n),
    .fire(elem_fire), .fire_bank(addr_bank),
    .query_bank(addr_bank),
    .busy_o(bank_busy)
  );
endmodule

// File: rtl/vsa_checker.sv
module vsa_checker #(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 2,
  parameter int MVL      = 8,
  parameter int VL_W     = 4,
  parameter int BUSY_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_fire,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_stride,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr_word,
  input logic [BANK_W-1:0] addr_bank,
  input logic              addr_first,
  input logic              addr_last,
  input logic [VL_W-1:0]   vl_out,
  input logic              done,
  input logic              elem_fire,
  input logic              bank_stall
);
  logic [ADDR_W-1:0] stride_cap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stride_cap <= '0;
    else if (cmd_fire) stride_cap <= cmd_stride;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_word)
      && $stable(addr_first) && $stable(addr_last));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    elem_fire && !addr_last |=> addr_word == $past(addr_word) + stride_cap);

  p_vl_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (vl_out != '0) && (vl_out <= VL_W'(MVL)));

  p_vl_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_first && $past(addr_valid) |-> $stable(vl_out));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> !cmd_ready);

  p_stall_hides_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_stall |-> !elem_fire);

  generate
    if (BUSY_CYC > 1) begin : g_bank_gap
      p_bank_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        elem_fire |=> !(addr_valid && addr_bank == $past(addr_bank)));
    end
  endgenerate
endmodule

bind vec_stride_agu vsa_checker #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .MVL(MVL), .VL_W(VL_W), .BUSY_CYC(BUSY_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_ready(cmd_ready),
  .cmd_stride(cmd_stride), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .addr_word(addr_word), .addr_bank(addr_bank), .addr_first(addr_first),
  .addr_last(addr_last), .vl_out(vl_out), .done(done),
  .elem_fire(elem_fire), .bank_stall(bank_stall)
);

// File: tb/vec_stride_agu_test.sv
`timescale 1ns/1ps
module vec_stride_agu_test;
  localparam int ADDR_W   = 16;
  localparam int CNT_W    = 10;
  localparam int MVL      = 8;
  localparam int NBANK    = 4;
  localparam int BUSY_CYC = 3;
  localparam int STARTUP  = 2;
  localparam int BANK_W   = $clog2(NBANK);
  localparam int VL_W     = $clog2(MVL + 1);
  localparam int AMASK    = (1 << ADDR_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [CNT_W-1:0] cmd_count = '0;
  logic [ADDR_W-1:0] cmd_base = '0;
  logic [ADDR_W-1:0] cmd_stride = '0;
  logic addr_valid;
  logic addr_ready = 1'b0;
  logic [ADDR_W-1:0] addr_word;
  logic [BANK_W-1:0] addr_bank;
  logic [ADDR_W-BANK_W-1:0] addr_offset;
  logic addr_first, addr_last, done;
  logic [VL_W-1:0] vl_out;

  always #2 clk = ~clk;

  vec_stride_agu #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MVL(MVL), .NBANK(NBANK),
    .BUSY_CYC(BUSY_CYC), .STARTUP(STARTUP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_count(cmd_count), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_word(addr_word),
    .addr_bank(addr_bank), .addr_offset(addr_offset), .addr_first(addr_first),
    .addr_last(addr_last), .vl_out(vl_out), .done(done)
  );

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int bfree [NBANK];

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // One command. rmode 0: always ready; rmode 1: ready stalls every third cycle.
  // noise: hold a junk command at the input while the block is busy (R10).
  task automatic run_op(input int n, input int base, input int stride,
                        input int rmode, input bit noise);
    int h, left, pos, sl, e, done_k, exp_a;
    bit exp_v;
    tick();
    cmd_valid  = 1'b1;
    cmd_count  = CNT_W'(n);
    cmd_base   = ADDR_W'(base);
    cmd_stride = ADDR_W'(stride);
    addr_ready = 1'b1;
    chk("R10", "cmd_ready at offer", cmd_ready, 1);
    h = cyc;
    left = n;
    pos = 0;
    exp_a = base & AMASK;
    sl = (n % MVL == 0) ? MVL : n % MVL;
    done_k = (n == 0) ? h + 1 : -1;
    e = max2(h + STARTUP + 2, bfree[exp_a & (NBANK - 1)]);
    forever begin
      tick();
      if (noise && left > 0) begin
        cmd_valid  = 1'b1;
        cmd_count  = CNT_W'(3);
        cmd_base   = ADDR_W'(16'h5555);
        cmd_stride = ADDR_W'(7);
      end else begin
        cmd_valid = 1'b0;
      end
      addr_ready = (rmode == 1) ? (cyc % 3 != 0) : 1'b1;
      if (cyc == done_k) begin
        chk("R9", "done after final element", done, 1);
        chk("R10", "cmd_ready back at done", cmd_ready, 1);
        chk("R9", "no address at done", addr_valid, 0);
        break;
      end
      chk("R9", "done quiet mid-run", done, 0);
      chk("R10", "cmd_ready low while busy", cmd_ready, 0);
      if (left > 0) begin
        exp_v = (cyc >= e);
        chk("R5 R6", "addr_valid timing", addr_valid, exp_v);
        if (addr_valid && exp_v) begin
          chk("R3 R8", "addr_word", addr_word, exp_a);
          chk("R4", "addr_bank", addr_bank, exp_a & (NBANK - 1));
          chk("R4", "addr_offset", addr_offset, exp_a >> BANK_W);
          chk("R11", "addr_first", addr_first, pos == 0);
          chk("R11", "addr_last", addr_last, pos == sl - 1);
          chk("R2", "vl_out", vl_out, sl);
          if (addr_ready) begin
            bfree[exp_a & (NBANK - 1)] = cyc + BUSY_CYC;
            left--;
            pos++;
            exp_a = (exp_a + stride) & AMASK;
            if (pos == sl) begin
              pos = 0;
              sl = MVL;
              if (left == 0) done_k = cyc + 1;
              else e = max2(cyc + STARTUP + 2, bfree[exp_a & (NBANK - 1)]);
            end else begin
              e = max2(cyc + 1, bfree[exp_a & (NBANK - 1)]);
            end
          end
        end else if (!exp_v) begin
          chk("R11", "flags quiet without valid", addr_first | addr_last, 0);
        end
      end else begin
        chk("R9", "no extra address", addr_valid, 0);
      end
      if (cyc - h > 5000) begin
        chk("R9", "run finished", 0, 1);
        break;
      end
    end
    cmd_valid = 1'b0;
    tick();
    chk("R9", "done is one cycle", done, 0);
    chk("R10", "idle after run", addr_valid, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick();
    chk("R1", "cmd_ready in reset", cmd_ready, 1);
    chk("R1", "addr_valid in reset", addr_valid, 0);
    chk("R1", "done in reset", done, 0);
    rst_n = 1'b1;
    tick();
    chk("R1", "cmd_ready after reset", cmd_ready, 1);
    chk("R1", "addr_valid after reset", addr_valid, 0);
  endtask

  task automatic t_short_strip();    run_op(5, 0, 1, 0, 0);      endtask // R2 single short strip
  task automatic t_multi_negative(); run_op(20, 10, -3, 0, 0);   endtask // R2 R3 wrap, strips 4,8,8
  task automatic t_exact_multiple(); run_op(16, 7, 5, 0, 0);     endtask // R2 strips 8,8
  task automatic t_bank_conflict();  run_op(12, 3, 4, 0, 0);     endtask // R6 every element same bank
  task automatic t_backpressure();   run_op(19, 100, 6, 1, 0);   endtask // R7
  task automatic t_zero_stride();    run_op(6, 40, 0, 0, 1);     endtask // R8 plus R10 noise
  task automatic t_zero_count();     run_op(0, 9, 1, 0, 0);      endtask // R9
  task automatic t_noise_stall();    run_op(9, 2, 2, 1, 1);      endtask // R7 R10

  initial begin
    for (int b = 0; b < NBANK; b++) bfree[b] = 0;
    t_reset();
    t_short_strip();
    t_multi_negative();
    t_exact_multiple();
    t_bank_conflict();
    t_backpressure();
    t_zero_stride();
    t_zero_count();
    t_noise_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule